// File: doc/BRIEF.md
# Interrupt Cause Collector

This block holds a register of pending interrupt causes and turns changes to that register into an interrupt signal for the host. Software can set cause bits with one register write and clear them with another. Two internal completion sources, a factorial engine and a DMA engine, set their own fixed bits with one-cycle pulses.

The signalling depends on the `msi_enable_i` input. When it is low, the block drives a level interrupt line. The line rises when a raise leaves any cause pending. It falls only when a clear empties the register.

When `msi_enable_i` is high, each raise that leaves causes pending posts a message request. The request is held until the fabric acknowledges it, and further raises in the meantime join that same request. Clears in this mode leave both the line and the request untouched. Reads are combinational from a read address.

Top module: `irq_cause_collector`

## Requirements
- R1: A write to offset 0x60 ORs the write data into the cause register, visible after the next clock edge.
- R2: A write to offset 0x64 clears every cause bit that is 1 in the write data and keeps all other bits.
- R3: Reading offset 0x24 returns the cause register combinationally; any other read offset returns zero.
- R4: A one-cycle pulse on `fact_done_i` sets cause bit 0 (value 0x1), and a pulse on `dma_done_i` sets cause bit 8 (value 0x100).
- R5: With `msi_enable_i` low, a raise (set write or completion pulse) that leaves the register nonzero drives `irq_line_o` to 1 one edge later.
- R6: `irq_line_o` falls only after a clear write that leaves the register zero while `msi_enable_i` is low. A clear that leaves bits pending keeps the line high.
- R7: With `msi_enable_i` high, a raise that leaves the register nonzero sets `msg_req_o` and does not touch `irq_line_o`. A clear write never sets `msg_req_o` and never changes `irq_line_o`.
- R8: A set write of zero data while the register is zero leaves the register zero, `irq_line_o` low and `msg_req_o` low.
- R9: When a completion pulse and a clear write of the same bit fall in the same cycle, the bit ends up set.
- R10: `msg_req_o` stays high until a cycle with `msg_ack_i` high. Raises while it is pending do not create another request, so one acknowledge drops it. A raise in the acknowledge cycle keeps it high.
- R11: After reset the register is zero and `irq_line_o` and `msg_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write offset |
| wr_data_i | input | CAUSE_W | Write data |
| rd_addr_i | input | ADDR_W | Read offset |
| rd_data_o | output | CAUSE_W | Read data |
| fact_done_i | input | 1 | Factorial completion pulse |
| dma_done_i | input | 1 | DMA completion pulse |
| msi_enable_i | input | 1 | Selects message signalling over the level line |
| irq_line_o | output | 1 | Level interrupt line |
| msg_req_o | output | 1 | Message interrupt request |
| msg_ack_i | input | 1 | Message request acknowledge |

## Verification
The legacy raise is tested with several set patterns, each spanning several bits. Partial clears that leave bits behind are checked apart from full clears, which tells "any clear drops the line" from "an empty register drops the line". Completion pulses are checked alone and in the same cycle as a clear of their bit, which shows whether set or clear takes priority. In message mode, zero-data raises, raises while a request is pending, and clears are each followed by acknowledges, which shows a merged request apart from a duplicated or spurious one. A last pass raises in legacy mode and clears in message mode, which shows the line is left stranded high as R7 requires.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam logic [31:0] RD_CAUSE_OFF = 32'h24;
  localparam logic [31:0] SET_OFF      = 32'h60;
  localparam logic [31:0] CLR_OFF      = 32'h64;
  localparam int unsigned FACT_BIT     = 0;
  localparam int unsigned DMA_BIT      = 8;
endpackage

// File: rtl/irq_cause_reg.sv
module irq_cause_reg
  import irq_cause_pkg::*;
#(
  parameter int unsigned CAUSE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sw_set_i,
  input  logic               sw_clr_i,
  input  logic [CAUSE_W-1:0] data_i,
  input  logic               fact_done_i,
  input  logic               dma_done_i,
  output logic [CAUSE_W-1:0] cause_q_o,
  output logic               raise_evt_o,
  output logic               lower_evt_o,
  output logic               next_zero_o
);
  logic [CAUSE_W-1:0] hw_set, set_vec, clr_vec, cause_d, cause_q;

  always_comb begin
    hw_set           = '0;
    hw_set[FACT_BIT] = fact_done_i;
    hw_set[DMA_BIT]  = dma_done_i;
    set_vec = hw_set | (sw_set_i ? data_i : '0);
    clr_vec = sw_clr_i ? data_i : '0;
    // set wins over a same-cycle clear
    cause_d = (cause_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= cause_d;
  end

  assign cause_q_o   = cause_q;
  assign raise_evt_o = sw_set_i | fact_done_i | dma_done_i;
  assign lower_evt_o = sw_clr_i;
  assign next_zero_o = (cause_d == '0);

  // R1
  sw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_set_i |=> ((cause_q & $past(data_i)) == $past(data_i)));
  // R2
  sw_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_clr_i && !fact_done_i && !dma_done_i) |=> ((cause_q & $past(data_i)) == '0));
  // R4
  fact_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fact_done_i |=> cause_q[FACT_BIT]);
  // R4
  dma_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_done_i |=> cause_q[DMA_BIT]);
endmodule

// File: rtl/irq_signal_ctrl.sv
module irq_signal_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raise_evt_i,
  input  logic lower_evt_i,
  input  logic next_zero_i,
  input  logic msi_enable_i,
  input  logic msg_ack_i,
  output logic irq_line_o,
  output logic msg_req_o
);
  logic fire, line_q, req_q;

  assign fire = raise_evt_i & ~next_zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      if (!msi_enable_i) begin
        if (fire)                          line_q <= 1'b1;
        else if (lower_evt_i && next_zero_i) line_q <= 1'b0;
      end
      // new raise outranks a same-cycle ack
      if (fire && msi_enable_i) req_q <= 1'b1;
      else if (msg_ack_i)       req_q <= 1'b0;
    end
  end

  assign irq_line_o = line_q;
  assign msg_req_o  = req_q;

  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !msg_ack_i) |=> req_q);
  // R7
  req_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(raise_evt_i && msi_enable_i));
  // R7
  line_msi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_enable_i |=> $stable(line_q));
endmodule

// File: rtl/irq_cause_collector.sv
module irq_cause_collector
  import irq_cause_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned CAUSE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [CAUSE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [CAUSE_W-1:0] rd_data_o,
  input  logic               fact_done_i,
  input  logic               dma_done_i,
  input  logic               msi_enable_i,
  output logic               irq_line_o,
  output logic               msg_req_o,
  input  logic               msg_ack_i
);
  localparam logic [ADDR_W-1:0] SET_A = SET_OFF[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] CLR_A = CLR_OFF[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] RD_A  = RD_CAUSE_OFF[ADDR_W-1:0];

  logic               sw_set, sw_clr, raise_evt, lower_evt, next_zero;
  logic [CAUSE_W-1:0] cause_q;

  assign sw_set = wr_en_i && (wr_addr_i == SET_A);
  assign sw_clr = wr_en_i && (wr_addr_i == CLR_A);

  irq_cause_reg #(.CAUSE_W(CAUSE_W)) u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sw_set_i    (sw_set),
    .sw_clr_i    (sw_clr),
    .data_i      (wr_data_i),
    .fact_done_i (fact_done_i),
    .dma_done_i  (dma_done_i),
    .cause_q_o   (cause_q),
    .raise_evt_o (raise_evt),
    .lower_evt_o (lower_evt),
    .next_zero_o (next_zero)
  );

  irq_signal_ctrl u_sig (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .raise_evt_i  (raise_evt),
    .lower_evt_i  (lower_evt),
    .next_zero_i  (next_zero),
    .msi_enable_i (msi_enable_i),
    .msg_ack_i    (msg_ack_i),
    .irq_line_o   (irq_line_o),
    .msg_req_o    (msg_req_o)
  );

  assign rd_data_o = (rd_addr_i == RD_A) ? cause_q : '0;

  // R6
  line_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_line_o) |-> (cause_q == '0));
  // R5
  line_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_line_o) |-> (cause_q != '0));
endmodule

// File: tb/tb_irq_cause_collector.sv
module tb_irq_cause_collector;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, fact = 0, dma = 0, msi = 0, ack = 0;
  logic [7:0]  wr_addr = 0, rd_addr = 8'h24;
  logic [31:0] wr_data = 0, rd_data;
  logic        line, req;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  irq_cause_collector dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .fact_done_i(fact), .dma_done_i(dma), .msi_enable_i(msi),
    .irq_line_o(line), .msg_req_o(req), .msg_ack_i(ack));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic cause_is(input string r, input logic [31:0] exp);
    rd_addr = 8'h24; #1;
    chk(r, rd_data, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(input logic f, input logic m);
    @(negedge clk); fact = f; dma = m;
    @(negedge clk); fact = 0; dma = 0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  task automatic t_reset();
    cause_is("R11 cause", 0);
    chk("R11 line", {31'b0, line}, 0);
    chk("R11 req", {31'b0, req}, 0);
  endtask

  task automatic t_legacy();
    msi = 0;
    wr(8'h60, 32'h5);
    cause_is("R1 set", 32'h5);
    chk("R5 line up", {31'b0, line}, 1);
    wr(8'h60, 32'h30);
    cause_is("R1 or", 32'h35);
    wr(8'h64, 32'h4);
    cause_is("R2 partial clr", 32'h31);
    chk("R6 line kept", {31'b0, line}, 1);
    rd_addr = 8'h20; #1;
    chk("R3 other offset", rd_data, 0);
    wr(8'h64, 32'hffff_ffff);
    cause_is("R2 full clr", 0);
    chk("R6 line down", {31'b0, line}, 0);
  endtask

  task automatic t_zero_raise();
    msi = 0;
    wr(8'h60, 0);
    cause_is("R8 cause", 0);
    chk("R8 line", {31'b0, line}, 0);
    msi = 1;
    wr(8'h60, 0);
    chk("R8 req", {31'b0, req}, 0);
    msi = 0;
  endtask

  task automatic t_internal();
    msi = 0;
    pulse(1, 0);
    cause_is("R4 fact bit0", 32'h1);
    chk("R5 line fact", {31'b0, line}, 1);
    pulse(0, 1);
    cause_is("R4 dma bit8", 32'h101);
    // R9: clear of bit0 in same cycle as fact pulse
    @(negedge clk); wr_en = 1; wr_addr = 8'h64; wr_data = 32'h101; fact = 1;
    @(negedge clk); wr_en = 0; fact = 0;
    cause_is("R9 set wins", 32'h1);
    chk("R9 line stays", {31'b0, line}, 1);
    wr(8'h64, 32'h1);
    cause_is("R2 drain", 0);
    chk("R6 drained", {31'b0, line}, 0);
  endtask

  task automatic t_msi();
    msi = 1;
    wr(8'h60, 32'h8);
    chk("R7 req up", {31'b0, req}, 1);
    chk("R7 line untouched", {31'b0, line}, 0);
    repeat (3) @(negedge clk);
    chk("R10 held", {31'b0, req}, 1);
    pulse(0, 1);
    cause_is("R4 dma in msi", 32'h108);
    chk("R10 merged", {31'b0, req}, 1);
    do_ack();
    chk("R10 single ack", {31'b0, req}, 0);
    // raise coincident with ack keeps request
    @(negedge clk); ack = 1; fact = 1;
    @(negedge clk); ack = 0; fact = 0;
    chk("R10 raise beats ack", {31'b0, req}, 1);
    do_ack();
    wr(8'h64, 32'h109);
    cause_is("R2 msi clr", 0);
    chk("R7 clr no req", {31'b0, req}, 0);
    chk("R7 clr no line", {31'b0, line}, 0);
  endtask

  task automatic t_asym();
    msi = 0;
    wr(8'h60, 32'h2);
    chk("R5 asym up", {31'b0, line}, 1);
    msi = 1;
    wr(8'h64, 32'h2);
    cause_is("R2 asym clr", 0);
    chk("R7 line stranded", {31'b0, line}, 1);
    chk("R7 no req on clr", {31'b0, req}, 0);
    msi = 0;
    wr(8'h64, 32'h0);
    chk("R6 legacy lower", {31'b0, line}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1; t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_legacy();
    t_zero_raise();
    t_internal();
    t_msi();
    t_asym();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule